// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers eight interrupt lines, latches each rising edge as a pending request, and raises a single interrupt to the processor when an enabled pending line is not held off by interrupts already being serviced. When the processor acknowledges, the block hands back an 8-bit vector made from a programmed base and the line number. In the same cycle it retires the pending request and, unless automatic end-of-interrupt is on, records the line as in service.

Software drives the block through a byte register port with three addresses. The command address takes the initialization start word, the read/mode command and the end-of-interrupt commands. Reads at that address return either the pending or the in-service set. The data address walks the rest of the initialization sequence, which is the vector base, a cascade word that is ignored, and an optional fourth word that picks automatic end-of-interrupt. After that sequence the data address carries the line mask. A third address holds a plain trigger-mode byte that only stores and reads back.

Top module: `prioirq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, a data-address read (reg_sel=1) returns 0xFF (all lines masked), a command-address read (reg_sel=0) returns the pending set 0x00, and a trigger-mode read (reg_sel=2) returns 0x00.
- R2: A line's pending bit is set only by a low-to-high change of its input. A line that is low clears its pending bit. A line held high after acknowledge is not captured again.
- R3: The winner is the lowest-numbered line that is both pending and enabled. A masked line never wins.
- R4: The winner is held off while the lowest in-service line has an index equal to or lower than the winner. A lower-numbered line can still nest.
- R5: With special mask mode on, only in-service lines that are currently enabled take part in the hold-off test. A command write with bit 4=0, bit 3=1 and bit 6=1 loads the mode from bit 5.
- R6: A command write with bit 4=1 starts initialization. It clears the pending set, the in-service set and the enables, turns automatic end-of-interrupt on, and latches bit 0 as "fourth word follows". The next two data writes are the vector base and then the cascade word.
- R7: With the sequence idle and a fourth word expected, the next data write is that word, and its bit 1 selects automatic end-of-interrupt. Every later data write is the mask, where bit i = 1 masks line i.
- R8: A command write with bit 4=0, bit 3=1 and bit 1=1 sets the read select from bit 0: 1 returns the in-service set at the command address and 0 returns the pending set.
- R9: A command write with bits 4 and 3 both 0 is an end-of-interrupt. If bits 7:5 = 011 it clears the in-service bit indexed by bits 2:0. Otherwise it clears the lowest set in-service bit.
- R10: The vector is the base OR the 3-bit winning line number. An acknowledge clears the winner's pending bit and sets its in-service bit only when automatic end-of-interrupt is off.
- R11: The trigger-mode register (reg_sel=2) reads back the last byte written to it.
- R12: The interrupt output follows the pending, enable and in-service state within the same cycle. An acknowledge while the output is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Interrupt request lines, edge captured |
| bus_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 command, 1 data, 2 trigger mode, 3 unused |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for the selected address |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge |
| vector | output | 8 | Vector, valid while int_out is high |

## Verification
The bench builds the block with its default eight lines and byte-wide data, so the specific end-of-interrupt index covers every line and the vector places the line number in bits 2:0 under the base. At this size a random run can reach every pair of winner and in-service line, including the equal-index hold-off and nesting past a masked in-service line under special mask mode. A bench model tracks the line levels, the initialization sequence and the register file, and the design must match it each cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_WANT_BASE = 2'd1,
    SEQ_WANT_CASC = 2'd2
  } seq_state_t;

  // index of the lowest set bit, or 32 when the vector is empty
  function automatic int unsigned first_set(input logic [31:0] v);
    int unsigned r;
    r = 32;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // keep only the lowest set bit
  function automatic logic [31:0] lowest_bit(input logic [31:0] v);
    return v & ~(v - 32'd1);
  endfunction

endpackage

// File: rtl/pic_edge_capture.sv
module pic_edge_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic         clr_all,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] lvl_q;
  logic [N-1:0] rise;

  assign rise = irq_in & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      irr   <= '0;
    end else begin
      lvl_q <= irq_in;
      if (clr_all) irr <= '0;
      else         irr <= ((irr & ~ack_clr) | rise) & irq_in;
    end
  end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  en,
  input  logic [N-1:0]  isr,
  input  logic          smm,
  output logic          req,
  output logic [IW-1:0] win_idx,
  output logic [N-1:0]  win_hot
);
  import pic_pkg::*;

  logic [N-1:0] cand;
  logic [N-1:0] isr_eff;
  logic         held;
  int unsigned  cand_pos;
  int unsigned  isr_pos;

  always_comb begin
    cand     = irr & en;
    isr_eff  = smm ? (isr & en) : isr;
    cand_pos = first_set(32'(cand));
    isr_pos  = first_set(32'(isr_eff));
    held     = (|isr_eff) && (isr_pos <= cand_pos);
    req      = (|cand) && !held;
    win_idx  = IW'(cand_pos);
    win_hot  = N'(lowest_bit(32'(cand)));
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] wdata,
  input  logic          ack_take,
  input  logic [N-1:0]  win_hot,
  output logic [N-1:0]  en,
  output logic [N-1:0]  isr,
  output logic [DW-1:0] base,
  output logic          aeoi,
  output logic          smm,
  output logic          rsel_isr,
  output logic [DW-1:0] trig,
  output logic          init_stb,
  output logic          eoi_stb
);
  import pic_pkg::*;

  seq_state_t   seq_q;
  logic         want4_q;
  logic         cmd_wr, data_wr, trig_wr, mode_stb;
  logic [N-1:0] eoi_clr, isr_set;

  assign cmd_wr   = bus_we && (reg_sel == 2'd0);
  assign data_wr  = bus_we && (reg_sel == 2'd1);
  assign trig_wr  = bus_we && (reg_sel == 2'd2);
  assign init_stb = cmd_wr && wdata[4];
  assign mode_stb = cmd_wr && !wdata[4] && wdata[3];
  assign eoi_stb  = cmd_wr && !wdata[4] && !wdata[3];

  always_comb begin
    if (wdata[7:5] == 3'b011) eoi_clr = N'(1) << wdata[IW-1:0];
    else                      eoi_clr = N'(lowest_bit(32'(isr)));
    isr_set = (ack_take && !aeoi) ? win_hot : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= '0;
      isr      <= '0;
      base     <= '0;
      aeoi     <= 1'b1;
      smm      <= 1'b0;
      rsel_isr <= 1'b0;
      trig     <= '0;
      seq_q    <= SEQ_IDLE;
      want4_q  <= 1'b0;
    end else begin
      if (init_stb) begin
        en      <= '0;
        isr     <= '0;
        aeoi    <= 1'b1;
        want4_q <= wdata[0];
        seq_q   <= SEQ_WANT_BASE;
      end else begin
        isr <= (isr | isr_set) & ~(eoi_stb ? eoi_clr : '0);
        if (mode_stb) begin
          if (wdata[1]) rsel_isr <= wdata[0];
          if (wdata[6]) smm      <= wdata[5];
        end
        if (data_wr) begin
          case (seq_q)
            SEQ_WANT_BASE: begin
              base  <= wdata;
              seq_q <= SEQ_WANT_CASC;
            end
            SEQ_WANT_CASC: seq_q <= SEQ_IDLE;
            default: begin
              if (want4_q) begin
                aeoi    <= wdata[1];
                want4_q <= 1'b0;
              end else begin
                en <= ~wdata[N-1:0];
              end
            end
          endcase
        end
      end
      if (trig_wr) trig <= wdata;
    end
  end
endmodule

// File: rtl/prioirq_ctrl.sv
module prioirq_ctrl #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          bus_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          int_out,
  input  logic          int_ack,
  output logic [DW-1:0] vector
);
  localparam int IW = $clog2(N);

  logic [N-1:0]  irr, en, isr, win_hot, ack_clr;
  logic [IW-1:0] win_idx;
  logic [DW-1:0] base, trig;
  logic          req, aeoi, smm, rsel_isr, init_stb, eoi_stb, ack_take;

  assign ack_take = int_ack && req;
  assign ack_clr  = ack_take ? win_hot : '0;

  pic_edge_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .clr_all(init_stb), .ack_clr(ack_clr), .irr(irr)
  );

  pic_resolver #(.N(N), .IW(IW)) u_res (
    .irr(irr), .en(en), .isr(isr), .smm(smm),
    .req(req), .win_idx(win_idx), .win_hot(win_hot)
  );

  pic_regs #(.N(N), .IW(IW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .reg_sel(reg_sel),
    .wdata(wdata), .ack_take(ack_take), .win_hot(win_hot),
    .en(en), .isr(isr), .base(base), .aeoi(aeoi), .smm(smm),
    .rsel_isr(rsel_isr), .trig(trig), .init_stb(init_stb), .eoi_stb(eoi_stb)
  );

  assign int_out = req;
  assign vector  = base | DW'(win_idx);

  always_comb begin
    case (reg_sel)
      2'd0:    rdata = rsel_isr ? DW'(isr) : DW'(irr);
      2'd1:    rdata = DW'(~en);
      2'd2:    rdata = trig;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          int_out,
  input logic          int_ack,
  input logic [N-1:0]  irq_in,
  input logic [N-1:0]  irr,
  input logic [N-1:0]  isr,
  input logic [N-1:0]  en,
  input logic          aeoi,
  input logic          init_stb,
  input logic          eoi_stb,
  input logic [IW-1:0] win_idx
);
  // R3
  win_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr[win_idx] && en[win_idx]));

  // R10
  ack_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_out && int_ack && !init_stb) |=> !irr[$past(win_idx)]);

  // R10
  ack_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_out && int_ack && !aeoi && !init_stb && !eoi_stb) |=> isr[$past(win_idx)]);

  // R6
  init_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_stb |=> (irr == '0 && isr == '0 && en == '0 && aeoi));

  // R12
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_out && !init_stb && !eoi_stb) |=> isr == $past(isr));

  for (genvar i = 0; i < N; i++) begin : g_line
    // R2
    low_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_in[i] |=> !irr[i]);
  end
endmodule

bind prioirq_ctrl pic_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_out(int_out), .int_ack(int_ack),
  .irq_in(irq_in), .irr(irr), .isr(isr), .en(en), .aeoi(aeoi),
  .init_stb(init_stb), .eoi_stb(eoi_stb), .win_idx(win_idx)
);

// File: tb/prioirq_ctrl_test.sv
module prioirq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       bus_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       int_out;
  logic       int_ack = 1'b0;
  logic [7:0] vector;

  int checks = 0;
  int errors = 0;

  // model state
  logic [7:0] m_lvl, m_irr, m_isr, m_en, m_base, m_trig;
  logic       m_aeoi, m_smm, m_rsel, m_w4;
  int         m_seq;
  // last sampled outputs
  logic       s_int;
  logic [7:0] s_vec, s_rd;

  always #10 clk = ~clk;

  prioirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .int_out(int_out),
    .int_ack(int_ack), .vector(vector)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int low_idx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 99;
  endfunction

  function automatic int m_win();
    return low_idx(m_irr & m_en);
  endfunction

  function automatic logic m_int();
    int w, s;
    w = m_win();
    s = low_idx(m_smm ? (m_isr & m_en) : m_isr);
    return (w != 99) && !(s != 99 && s <= w);
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] sel);
    case (sel)
      2'd0: return m_rsel ? m_isr : m_irr;
      2'd1: return ~m_en;
      2'd2: return m_trig;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    m_lvl = 0; m_irr = 0; m_isr = 0; m_en = 0; m_base = 0; m_trig = 0;
    m_aeoi = 1; m_smm = 0; m_rsel = 0; m_w4 = 0; m_seq = 0;
  endtask

  task automatic m_step(input logic [7:0] irq, input logic ack, input logic we,
                        input logic [1:0] sel, input logic [7:0] d);
    logic [7:0] nirr, nisr, clr;
    int w;
    nirr = m_irr; nisr = m_isr; clr = 0;
    w = m_win();
    if (ack && m_int()) begin
      nirr[w] = 1'b0;
      if (!m_aeoi) nisr[w] = 1'b1;
    end
    for (int i = 0; i < 8; i++) begin
      if (irq[i] && !m_lvl[i]) nirr[i] = 1'b1;
      if (!irq[i]) nirr[i] = 1'b0;
    end
    m_lvl = irq;
    if (we && sel == 2'd0) begin
      if (d[4]) begin
        nirr = 0; nisr = 0; m_en = 0; m_aeoi = 1; m_w4 = d[0]; m_seq = 1;
      end else if (d[3]) begin
        if (d[1]) m_rsel = d[0];
        if (d[6]) m_smm = d[5];
      end else begin
        if (d[7:5] == 3'b011) clr[d[2:0]] = 1'b1;
        else if (m_isr != 0) clr[low_idx(m_isr)] = 1'b1;
        nisr = nisr & ~clr;
      end
    end
    if (we && sel == 2'd1) begin
      if (m_seq == 1) begin m_base = d; m_seq = 2; end
      else if (m_seq == 2) m_seq = 0;
      else if (m_w4) begin m_aeoi = d[1]; m_w4 = 0; end
      else m_en = ~d;
    end
    if (we && sel == 2'd2) m_trig = d;
    m_irr = nirr; m_isr = nisr;
  endtask

  task automatic cyc(input logic [7:0] irq, input logic ack, input logic we,
                     input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    irq_in = irq; int_ack = ack; bus_we = we; reg_sel = sel; wdata = d;
    #1;
    s_int = int_out; s_vec = vector; s_rd = rdata;
    chk("R12 int_out vs model", {7'd0, int_out}, {7'd0, m_int()});
    if (m_int()) chk("R10 vector vs model", vector, m_base | 8'(m_win()));
    chk("R8 rdata vs model", rdata, m_read(sel));
    m_step(irq, ack, we, sel, d);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] irq;
    void'($urandom(32'h5EED_0042));
    m_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cyc(8'h00, 0, 0, 2'd1, 8'h00); chk("R1 mask after reset", s_rd, 8'hFF);
    chk("R1 int low", {7'd0, s_int}, 8'h00);
    cyc(8'h00, 0, 0, 2'd0, 8'h00); chk("R1 cmd read", s_rd, 8'h00);
    cyc(8'h00, 0, 0, 2'd2, 8'h00); chk("R1 trig read", s_rd, 8'h00);

    // R6/R7 init: base 0x40, fourth word with aeoi off, mask none
    cyc(8'h00, 0, 1, 2'd0, 8'h11);
    cyc(8'h00, 0, 1, 2'd1, 8'h40);
    cyc(8'h00, 0, 1, 2'd1, 8'h99);
    cyc(8'h00, 0, 0, 2'd1, 8'h00); chk("R6 mask cleared by init", s_rd, 8'hFF);
    cyc(8'h00, 0, 1, 2'd1, 8'h01);
    cyc(8'h00, 0, 1, 2'd1, 8'h00);
    cyc(8'h00, 0, 0, 2'd1, 8'h00); chk("R7 mask word", s_rd, 8'h00);

    // R3 lines 3 and 5
    cyc(8'h28, 0, 0, 2'd0, 8'h00);
    cyc(8'h28, 0, 0, 2'd0, 8'h00);
    chk("R3 int up", {7'd0, s_int}, 8'h01);
    chk("R3 vector line 3", s_vec, 8'h43);
    chk("R2 pending set", s_rd, 8'h28);
    cyc(8'h28, 1, 0, 2'd0, 8'h00);
    cyc(8'h28, 0, 1, 2'd0, 8'h0B);
    chk("R4 line 5 held off", {7'd0, s_int}, 8'h00);
    chk("R10 ack clears pending", s_rd, 8'h20);
    cyc(8'h28, 0, 0, 2'd0, 8'h00); chk("R8 isr read", s_rd, 8'h08);

    // R4 nesting by line 1
    cyc(8'h2A, 0, 0, 2'd0, 8'h00);
    cyc(8'h2A, 0, 0, 2'd0, 8'h00);
    chk("R4 nest int", {7'd0, s_int}, 8'h01);
    chk("R4 nest vector", s_vec, 8'h41);
    cyc(8'h2A, 1, 0, 2'd0, 8'h00);
    cyc(8'h2A, 0, 0, 2'd0, 8'h00); chk("R10 isr after nest", s_rd, 8'h0A);

    // R9 end of interrupt forms
    cyc(8'h2A, 0, 1, 2'd0, 8'h20);
    cyc(8'h2A, 0, 0, 2'd0, 8'h00); chk("R9 nonspecific", s_rd, 8'h08);
    cyc(8'h2A, 0, 1, 2'd0, 8'h63);
    cyc(8'h2A, 0, 0, 2'd0, 8'h00);
    chk("R9 specific", s_rd, 8'h00);
    chk("R9 line 5 released", s_vec, 8'h45);
    cyc(8'h2A, 1, 0, 2'd0, 8'h00);

    // R5 special mask mode, isr = line 5
    cyc(8'h00, 0, 0, 2'd0, 8'h00);
    cyc(8'h40, 0, 0, 2'd0, 8'h00);
    cyc(8'h40, 0, 0, 2'd0, 8'h00); chk("R4 line 6 held", {7'd0, s_int}, 8'h00);
    cyc(8'h40, 0, 1, 2'd1, 8'h20);
    cyc(8'h40, 0, 0, 2'd0, 8'h00); chk("R5 held without mode", {7'd0, s_int}, 8'h00);
    cyc(8'h40, 0, 1, 2'd0, 8'h68);
    cyc(8'h40, 0, 0, 2'd0, 8'h00);
    chk("R5 int in mode", {7'd0, s_int}, 8'h01);
    chk("R5 vector", s_vec, 8'h46);
    cyc(8'h40, 0, 1, 2'd0, 8'h48);
    cyc(8'h40, 0, 0, 2'd0, 8'h00); chk("R5 mode off", {7'd0, s_int}, 8'h00);

    // R2 falling line drops pending
    cyc(8'h40, 0, 1, 2'd0, 8'h0A);
    cyc(8'h00, 0, 0, 2'd0, 8'h00);
    cyc(8'h00, 0, 0, 2'd0, 8'h00); chk("R2 low clears", s_rd, 8'h00);

    // R2 held high not recaptured; R12 idle ack
    cyc(8'h00, 0, 1, 2'd0, 8'h20);
    cyc(8'h80, 0, 0, 2'd0, 8'h00);
    cyc(8'h80, 1, 0, 2'd0, 8'h00); chk("R3 line 7 vector", s_vec, 8'h47);
    cyc(8'h80, 0, 1, 2'd0, 8'h20);
    cyc(8'h80, 0, 0, 2'd0, 8'h00);
    cyc(8'h80, 0, 0, 2'd0, 8'h00);
    chk("R2 no recapture int", {7'd0, s_int}, 8'h00);
    chk("R2 no recapture pending", s_rd, 8'h00);
    cyc(8'h80, 1, 1, 2'd0, 8'h0B);
    cyc(8'h80, 0, 0, 2'd0, 8'h00); chk("R12 idle ack", s_rd, 8'h00);

    // R11 trigger register
    cyc(8'h00, 0, 1, 2'd2, 8'hA5);
    cyc(8'h00, 0, 0, 2'd2, 8'h00); chk("R11 readback", s_rd, 8'hA5);

    // R7/R10 automatic end of interrupt
    cyc(8'h00, 0, 1, 2'd0, 8'h13);
    cyc(8'h00, 0, 1, 2'd1, 8'h20);
    cyc(8'h00, 0, 1, 2'd1, 8'h00);
    cyc(8'h00, 0, 1, 2'd1, 8'h03);
    cyc(8'h00, 0, 1, 2'd1, 8'h00);
    cyc(8'h04, 0, 0, 2'd0, 8'h00);
    cyc(8'h04, 1, 0, 2'd0, 8'h00); chk("R10 vector base 20", s_vec, 8'h22);
    cyc(8'h04, 0, 1, 2'd0, 8'h0B);
    cyc(8'h04, 0, 0, 2'd0, 8'h00); chk("R10 aeoi no isr", s_rd, 8'h00);
    cyc(8'h00, 0, 1, 2'd0, 8'h11);
    cyc(8'h00, 0, 1, 2'd1, 8'h80);
    cyc(8'h00, 0, 1, 2'd1, 8'h00);
    cyc(8'h00, 0, 1, 2'd1, 8'h01);

    // random phase against the model
    irq = 8'h00;
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] d;
      logic [1:0] sel;
      logic we, ack;
      int k;
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 9) == 0) irq[b] = ~irq[b];
      ack = ($urandom_range(0, 2) == 0);
      we  = ($urandom_range(0, 4) == 0);
      sel = 2'($urandom_range(0, 3));
      d   = 8'($urandom);
      k   = $urandom_range(0, 19);
      if (sel == 2'd0) begin
        if (k == 0)      d = d | 8'h10;
        else if (k < 10) d = d & 8'hE7;
        else             d = (d & 8'hEF) | 8'h08;
      end
      if (sel == 2'd1 && we) d = d & 8'($urandom);
      cyc(irq, ack, we, sel, d);
    end

    @(negedge clk);
    bus_we = 0; int_ack = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule